// File: doc/BRIEF.md
# Start-Stop Prescaled Down-Counter Timer

This block is a memory-mapped timer. It has a 32-bit down-counter driven by a 32-bit prescaler. Software sees four aligned word registers:

- a control register,
- a status register,
- a prescale register,
- a count register.

A single write to the control register toggles the timer. If the timer is idle, the write starts it. If it is running, the write stops it. The data written does not matter.

While the timer is idle, software loads the prescale period and the initial count. While it runs, both of these settings are frozen against writes. The count register shows the stored initial value while idle and the live count while running. The timer stops by itself when the count reaches zero.

The bus side is a plain strobe interface. A write takes effect on the clock edge that samples it. Read data is combinational from the address while the read strobe is high.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the timer is idle. Status bit 0 reads 1. The prescale register reads 0. The count register reads 0.
- R2: A write to the control register (byte offset 0x0) while status bit 0 is 1 starts the timer. From the next cycle status bit 0 reads 0. The written data is ignored.
- R3: A write to the control register while status bit 0 is 0 stops the timer. From the next cycle status bit 0 reads 1.
- R4: Writes to the prescale register (offset 0x8) are ignored while running. While idle they are stored and read back.
- R5: Writes to the count register (offset 0xC) are ignored while running. While idle, reading offset 0xC returns the stored initial value.
- R6: While running, offset 0xC returns the live count. The count drops by one every P clocks, where P is the prescale value and a value of 0 acts as 1.
- R7: When the live count reaches zero, the timer stops by itself and status bit 0 returns to 1. An initial value of 0 expires after one prescale period.
- R8: Every start copies the stored initial count and prescale into the working counters. A stop followed by a start resumes from the initial value.
- R9: Only address bits [3:2] select the register, so bits [1:0] are ignored. Status bits [31:1] read 0. The control register reads 0. Read data is 0 while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, enables read data |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
The bench builds the block with its default widths: a 32-bit counter, a 32-bit prescaler and a 4-bit address. It loads small prescale and count values, so that expiry, a zero prescale acting as one, and a zero initial count all occur within a few dozen cycles. A vector table sets the number of cycles each run is left to count. This lands reads both mid-run and after self-stop, and each expected value is worked out by hand from the tick rule. Directed cases cover writes during a run, stop-then-restart, alias addresses and a reset taken mid-run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_STAT  = 2'd1,
        REG_PRE   = 2'd2,
        REG_COUNT = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        logic ctrl;
        logic pre;
        logic count;
    } tmr_wr_s;

    function automatic tmr_reg_e reg_of(input logic [1:0] idx);
        return tmr_reg_e'(idx);
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output tmr_wr_s           wr,
    output tmr_reg_e          sel
);
    logic [1:0] unused_low;

    assign unused_low = bus_addr[1:0];
    assign sel        = reg_of(bus_addr[3:2]);

    always_comb begin
        wr       = '0;
        wr.ctrl  = bus_wr && (sel == REG_CTRL);
        wr.pre   = bus_wr && (sel == REG_PRE);
        wr.count = bus_wr && (sel == REG_COUNT);
    end
endmodule

// File: rtl/tmr_cfg.sv
module tmr_cfg
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_q,
    input  tmr_wr_s          wr,
    input  logic [BUS_W-1:0] wdata,
    output logic [PRE_W-1:0] pre_cfg,
    output logic [CNT_W-1:0] init_cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cfg  <= '0;
            init_cfg <= '0;
        end else if (!run_q) begin
            if (wr.pre)   pre_cfg  <= wdata[PRE_W-1:0];
            if (wr.count) init_cfg <= wdata[CNT_W-1:0];
        end
    end

    AST_PRE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (run_q && wr.pre) |=> $stable(pre_cfg)); // R4
    AST_INIT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (run_q && wr.count) |=> $stable(init_cfg)); // R5
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run_q,
    input  logic [PRE_W-1:0] pre_cfg,
    output logic             tick
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] period;

    assign period = (pre_cfg == '0) ? ONE : pre_cfg;
    assign tick   = run_q && (pre_cnt <= ONE);

    always_ff @(posedge clk) begin
        if (rst)       pre_cnt <= ONE;
        else if (load) pre_cnt <= period;
        else if (tick) pre_cnt <= period;
        else if (run_q) pre_cnt <= pre_cnt - ONE;
    end

    AST_PRE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (pre_cnt != '0)); // R6
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             tick,
    input  logic [CNT_W-1:0] init_cfg,
    output logic             start,
    output logic             run_q,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic stop;

    assign start = ctrl_wr && !run_q;
    assign stop  = ctrl_wr && run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= init_cfg;
        end else if (stop) begin
            run_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q <= ONE) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !run_q) |=> run_q); // R2
    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && run_q) |=> !run_q); // R3
    AST_CNT_NONINC: assert property (@(posedge clk) disable iff (rst)
        (run_q && !ctrl_wr) |=> (cnt_q <= $past(cnt_q))); // R6
    AST_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && !ctrl_wr && cnt_q <= ONE) |=> !run_q); // R7
    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !run_q) |=> (cnt_q == $past(init_cfg))); // R8
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    tmr_wr_s          wr;
    tmr_reg_e         sel;
    logic [PRE_W-1:0] pre_cfg;
    logic [CNT_W-1:0] init_cfg;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             start;
    logic             tick;

    tmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr       (wr),
        .sel      (sel)
    );

    tmr_cfg #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .run_q    (run_q),
        .wr       (wr),
        .wdata    (bus_wdata),
        .pre_cfg  (pre_cfg),
        .init_cfg (init_cfg)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .run_q   (run_q),
        .pre_cfg (pre_cfg),
        .tick    (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (wr.ctrl),
        .tick     (tick),
        .init_cfg (init_cfg),
        .start    (start),
        .run_q    (run_q),
        .cnt_q    (cnt_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                REG_CTRL:  bus_rdata = '0;
                REG_STAT:  bus_rdata = {31'd0, !run_q};
                REG_PRE:   bus_rdata = 32'(pre_cfg);
                REG_COUNT: bus_rdata = run_q ? 32'(cnt_q) : 32'(init_cfg);
            endcase
        end
    end
endmodule

// File: tb/sim_prescaled_timer.sv
`timescale 1ns/1ps
module sim_prescaled_timer;
    localparam int NV = 8;
    localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_PRE = 4'h8, A_CNT = 4'hC;

    // stimulus: prescale, initial count, cycles waited after start
    localparam int V_PRE  [NV] = '{3, 0, 1, 5, 2, 2, 0, 4};
    localparam int V_INIT [NV] = '{5, 4, 4, 2, 0, 0, 1, 3};
    localparam int V_WAIT [NV] = '{7, 2, 4, 9, 1, 2, 0, 12};
    // expected: count read, status bit 0
    localparam int V_XCNT [NV] = '{3, 2, 4, 1, 0, 0, 1, 3};
    localparam int V_XRDY [NV] = '{0, 0, 1, 0, 0, 1, 0, 1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    prescaled_timer u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_STAT, v); check("R1 status after reset", v, 32'd1);
        rd(A_PRE, v);  check("R1 prescale after reset", v, 32'd0);
        rd(A_CNT, v);  check("R1 count after reset", v, 32'd0);
        bus_addr = A_STAT; #1;
        check("R9 rdata with read strobe low", bus_rdata, 32'd0);
        rd(A_CTRL, v); check("R9 control reads zero", v, 32'd0);

        // vector table: R2 R6 R7
        for (int i = 0; i < NV; i++) begin
            wr(A_PRE, V_PRE[i]);
            wr(A_CNT, V_INIT[i]);
            wr(A_CTRL, 32'hDEAD_BEEF);
            repeat (V_WAIT[i]) @(negedge clk);
            rd(A_CNT, v);  check($sformatf("R6/R7 vector %0d count", i), v, V_XCNT[i]);
            rd(A_STAT, v); check($sformatf("R2/R7 vector %0d status", i), v, V_XRDY[i]);
            if (V_XRDY[i] == 0) begin
                wr(A_CTRL, 32'd0);
                rd(A_STAT, v); check($sformatf("R3 vector %0d stop", i), v, 32'd1);
            end
        end

        // R4 R5 writes locked while running
        wr(A_PRE, 2);
        wr(A_CNT, 10);
        wr(A_CTRL, 0);
        wr(A_PRE, 7);
        wr(A_CNT, 99);
        rd(A_CNT, v); check("R6 live count after two cycles", v, 32'd9);
        wr(A_CTRL, 0);
        rd(A_PRE, v); check("R4 prescale write ignored while running", v, 32'd2);
        rd(A_CNT, v); check("R5 count write ignored while running", v, 32'd10);
        wr(A_PRE, 6);
        rd(A_PRE, v); check("R4 prescale write accepted while idle", v, 32'd6);

        // R8 restart from initial value
        wr(A_PRE, 1);
        wr(A_CTRL, 0);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); check("R8 count before stop", v, 32'd7);
        wr(A_CTRL, 0);
        wr(A_CTRL, 0);
        rd(A_CNT, v); check("R8 restart reloads initial", v, 32'd10);
        wr(A_CTRL, 0);

        // R9 low address bits ignored
        wr(4'hA, 5);
        rd(A_PRE, v); check("R9 alias write lands in prescale", v, 32'd5);
        rd(4'hB, v);  check("R9 alias read of prescale", v, 32'd5);
        rd(4'h5, v);  check("R9 alias status only bit 0", v, 32'd1);

        // R1 reset taken mid-run
        wr(A_CTRL, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(A_STAT, v); check("R1 status after mid-run reset", v, 32'd1);
        rd(A_PRE, v);  check("R1 prescale after mid-run reset", v, 32'd0);
        rd(A_CNT, v);  check("R1 count after mid-run reset", v, 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule